// File: doc/BRIEF.md
# Two-Slot Method Instruction Cache

This block is the instruction store of a stack-based processor that keeps whole methods rather than lines. It has two storage slots. Each slot holds one complete method, and a method longer than one slot fills both. The cache is consulted only when the processor calls a method or returns to one. At that moment the method start address is compared against the two slot tags. On a hit, execution continues at once from the matching slot. On a miss, every word of the method is copied from a 32-bit main memory, and `busy` stays high until the copy is complete.

Once a method is resident, the processor reads instruction bytes through a fetch port using offsets counted from the start of the method. No tag compare or address translation happens on these reads, so ordinary fetches never miss. The slot to overwrite on a miss is chosen by a single least-recently-used bit. That bit is updated on every call and return, whether the lookup hits or misses.

Top module: `method_cache`

## Requirements
- R1: After reset, `busy` and `memRdReq` are low and both slots are empty, so the first lookup misses.
- R2: A lookup request (`reqValid` high while `busy` is low) whose `reqAddr` matches a resident method is a hit. On a hit, `busy` stays low, no memory read is issued, and fetches from the next cycle on read that method.
- R3: On a miss, `busy` is high from the cycle after the request until the cycle after the acknowledge of the last word. The memory reads use addresses `reqAddr`, `reqAddr+1`, … up to `reqAddr+reqLen-1`, in that order. With `memRdAck` held high, `busy` stays high for exactly `reqLen` cycles.
- R4: `fetchByte` for offset `o` is byte `o mod 4` of method word `o/4`, where byte 0 is bits 7:0 of the word (little-endian).
- R5: With short methods F, A and B, the sequence call F, call A, return to F, call B, return to F yields miss, miss, hit, miss, hit.
- R6: With short methods F, A and B, the sequence call F, call A, call B, return to A, return to F yields miss, miss, miss, hit, miss. The final reload of F replaces B and leaves A resident.
- R7: A method with `reqLen` greater than `BLOCK_WORDS` occupies both slots, and all of its bytes can be fetched. A later miss on a short method evicts the long method, so the next lookup of the long method misses.
- R8: A request made while `busy` is high is ignored. The fill in progress completes unchanged, and the ignored method is not made resident.
- R9: While `memRdAck` is low, the fill waits with a stable `memRdAddr`. A fill with stalled acknowledges delivers the same bytes as an unstalled one.
- R10: Legal request lengths run from 1 to `2*BLOCK_WORDS` words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Call or return lookup request |
| reqAddr | input | ADDR_W | Word address of the method start |
| reqLen | input | LEN_W | Method length in words |
| busy | output | 1 | Method fill in progress |
| memRdReq | output | 1 | Main-memory read request |
| memRdAddr | output | ADDR_W | Main-memory word address |
| memRdAck | input | 1 | Read data valid this cycle |
| memRdData | input | 32 | Main-memory read word |
| fetchOffset | input | OFF_W | Byte offset from the method start |
| fetchByte | output | 8 | Instruction byte at that offset |

## Verification
A stale tag or a wrong replacement bit does not fail the request that causes it. It shows up one or two lookups later, as a hit where a miss was due or the reverse, visible in `busy` one cycle after that request. For this reason, the call and return sequences are checked lookup by lookup. A wrong slot pointer or a wrong write index shows up in `fetchByte` right after the fill. To catch it, every byte of each filled method is swept against a value computed from its address.

// File: rtl/method_cache_pkg.sv
package method_cache_pkg;
  typedef struct packed {
    logic wrEn;    // store one fill word this cycle
    logic wrBlk;   // slot the fill starts in
    logic curBlk;  // slot holding the executing method
  } cacheStrobes_t;
endpackage

// File: rtl/method_cache_ctrl.sv
module method_cache_ctrl
  import method_cache_pkg::*;
#(
  parameter int BLOCK_WORDS = 8,
  parameter int ADDR_W      = 16,
  parameter int LEN_W       = $clog2(2 * BLOCK_WORDS + 1),
  parameter int IDX_W       = $clog2(2 * BLOCK_WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [LEN_W-1:0]  reqLen,
  input  logic              memRdAck,
  output logic              busy,
  output logic              memRdReq,
  output logic [ADDR_W-1:0] memRdAddr,
  output logic [IDX_W-1:0]  wrWord,
  output cacheStrobes_t     strobes
);
  localparam int SLOTS = 2;

  logic [ADDR_W-1:0] tagAddr [SLOTS];
  logic [SLOTS-1:0]  tagValid;
  logic [SLOTS-1:0]  hitVec;
  logic              spanning;
  logic              lru;
  logic              curBlk;
  logic              fillBlk;
  logic              filling;
  logic [ADDR_W-1:0] fillBase;
  logic [LEN_W-1:0]  fillLen;
  logic [LEN_W-1:0]  fillCnt;
  logic              accept;
  logic              isLarge;
  logic              lastWord;

  for (genvar s = 0; s < SLOTS; s++) begin : g_cmp
    assign hitVec[s] = tagValid[s] && (tagAddr[s] == reqAddr);
  end

  assign accept   = reqValid && !filling;
  assign isLarge  = reqLen > LEN_W'(BLOCK_WORDS);
  assign lastWord = fillCnt == (fillLen - LEN_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tagValid <= '0;
      tagAddr  <= '{default: '0};
      spanning <= 1'b0;
      lru      <= 1'b0;
      curBlk   <= 1'b0;
      fillBlk  <= 1'b0;
      filling  <= 1'b0;
      fillBase <= '0;
      fillLen  <= '0;
      fillCnt  <= '0;
    end else if (accept) begin
      if (hitVec[0]) begin
        curBlk <= 1'b0;
        lru    <= 1'b1;
      end else if (hitVec[1]) begin
        curBlk <= 1'b1;
        lru    <= 1'b0;
      end else begin
        filling  <= 1'b1;
        fillBase <= reqAddr;
        fillLen  <= reqLen;
        fillCnt  <= '0;
        if (isLarge) begin
          fillBlk     <= 1'b0;
          curBlk      <= 1'b0;
          lru         <= 1'b1;
          tagAddr[0]  <= reqAddr;
          tagValid[0] <= 1'b1;
          tagValid[1] <= 1'b0;
          spanning    <= 1'b1;
        end else begin
          fillBlk       <= lru;
          curBlk        <= lru;
          lru           <= ~lru;
          tagAddr[lru]  <= reqAddr;
          tagValid[lru] <= 1'b1;
          if (lru) begin
            if (spanning) tagValid[0] <= 1'b0;
          end else begin
            spanning <= 1'b0;
          end
        end
      end
    end else if (filling && memRdAck) begin
      fillCnt <= fillCnt + LEN_W'(1);
      if (lastWord) filling <= 1'b0;
    end
  end

  assign busy           = filling;
  assign memRdReq       = filling;
  assign memRdAddr      = fillBase + ADDR_W'(fillCnt);
  assign wrWord         = fillCnt[IDX_W-1:0];
  assign strobes.wrEn   = filling && memRdAck;
  assign strobes.wrBlk  = fillBlk;
  assign strobes.curBlk = curBlk;

  a_r10_len_legal: assert property (@(posedge clk) disable iff (!rstN)
    accept |-> (reqLen >= LEN_W'(1) && reqLen <= LEN_W'(2 * BLOCK_WORDS)));
  a_r3_count_in_range: assert property (@(posedge clk) disable iff (!rstN)
    filling |-> fillCnt < fillLen);
  a_r3_busy_drops: assert property (@(posedge clk) disable iff (!rstN)
    (filling && memRdAck && lastWord) |=> !busy);
  a_r2_hit_stays_idle: assert property (@(posedge clk) disable iff (!rstN)
    (accept && |hitVec) |=> !busy);
  a_r5_lru_away: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> (lru != curBlk));
  a_r5_tags_distinct: assert property (@(posedge clk) disable iff (!rstN)
    !(tagValid[0] && tagValid[1] && tagAddr[0] == tagAddr[1]));
  a_r7_span_owns_both: assert property (@(posedge clk) disable iff (!rstN)
    (spanning && tagValid[0]) |-> !tagValid[1]);
  a_r9_stall_holds: assert property (@(posedge clk) disable iff (!rstN)
    (filling && !memRdAck) |=> (busy && $stable(memRdAddr)));
  a_r8_busy_ignores: assert property (@(posedge clk) disable iff (!rstN)
    (filling && !memRdAck) |=> $stable(fillBase));
endmodule

// File: rtl/method_cache_data.sv
module method_cache_data
  import method_cache_pkg::*;
#(
  parameter int BLOCK_WORDS = 8,
  parameter int IDX_W       = $clog2(2 * BLOCK_WORDS),
  parameter int OFF_W       = IDX_W + 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  cacheStrobes_t    strobes,
  input  logic [IDX_W-1:0] wrWord,
  input  logic [31:0]      wrData,
  input  logic [OFF_W-1:0] fetchOffset,
  output logic [7:0]       fetchByte
);
  localparam int TOTAL_WORDS = 2 * BLOCK_WORDS;

  logic [31:0]      words [TOTAL_WORDS];
  logic [IDX_W-1:0] wrIdx;
  logic [OFF_W-1:0] absByte;
  logic [31:0]      rdWord;

  // slot select flips the top index bit; a spanning method starts at slot 0
  assign wrIdx   = {strobes.wrBlk ^ wrWord[IDX_W-1], wrWord[IDX_W-2:0]};
  assign absByte = {strobes.curBlk ^ fetchOffset[OFF_W-1], fetchOffset[OFF_W-2:0]};

  always_ff @(posedge clk) begin
    if (strobes.wrEn) words[wrIdx] <= wrData;
  end

  assign rdWord = words[absByte[OFF_W-1:2]];

  always_comb begin
    fetchByte = 8'h00;
    for (int b = 0; b < 4; b++) begin
      if (absByte[1:0] == 2'(b)) fetchByte = rdWord[8*b +: 8];
    end
  end

  a_r4_write_lands: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrEn |=> words[$past(wrIdx)] == $past(wrData));
endmodule

// File: rtl/method_cache.sv
module method_cache
  import method_cache_pkg::*;
#(
  parameter int BLOCK_WORDS = 8,
  parameter int ADDR_W      = 16,
  parameter int LEN_W       = $clog2(2 * BLOCK_WORDS + 1),
  parameter int OFF_W       = $clog2(2 * BLOCK_WORDS) + 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [LEN_W-1:0]  reqLen,
  output logic              busy,
  output logic              memRdReq,
  output logic [ADDR_W-1:0] memRdAddr,
  input  logic              memRdAck,
  input  logic [31:0]       memRdData,
  input  logic [OFF_W-1:0]  fetchOffset,
  output logic [7:0]        fetchByte
);
  localparam int IDX_W = $clog2(2 * BLOCK_WORDS);

  cacheStrobes_t    strobes;
  logic [IDX_W-1:0] wrWord;

  method_cache_ctrl #(
    .BLOCK_WORDS(BLOCK_WORDS), .ADDR_W(ADDR_W), .LEN_W(LEN_W), .IDX_W(IDX_W)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqLen(reqLen), .memRdAck(memRdAck), .busy(busy), .memRdReq(memRdReq),
    .memRdAddr(memRdAddr), .wrWord(wrWord), .strobes(strobes)
  );

  method_cache_data #(
    .BLOCK_WORDS(BLOCK_WORDS), .IDX_W(IDX_W), .OFF_W(OFF_W)
  ) uData (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrWord(wrWord),
    .wrData(memRdData), .fetchOffset(fetchOffset), .fetchByte(fetchByte)
  );
endmodule

// File: tb/method_cache_test.sv
module method_cache_test;
  localparam int BW     = 8;
  localparam int ADDR_W = 16;
  localparam int LEN_W  = $clog2(2 * BW + 1);
  localparam int OFF_W  = $clog2(2 * BW) + 2;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              reqValid = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [LEN_W-1:0]  reqLen = '0;
  logic              busy, memRdReq, memRdAck;
  logic [ADDR_W-1:0] memRdAddr;
  logic [31:0]       memRdData;
  logic [OFF_W-1:0]  fetchOffset = '0;
  logic [7:0]        fetchByte;
  logic              slowAck = 1'b0;
  logic              ackToggle = 1'b0;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  method_cache uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqLen(reqLen), .busy(busy), .memRdReq(memRdReq), .memRdAddr(memRdAddr),
    .memRdAck(memRdAck), .memRdData(memRdData), .fetchOffset(fetchOffset),
    .fetchByte(fetchByte)
  );

  function automatic logic [7:0] memByte(int byteAddr);
    return 8'(byteAddr & 255) ^ 8'h5A;
  endfunction

  always @(posedge clk) ackToggle <= ~ackToggle;
  assign memRdAck = memRdReq && (slowAck ? ackToggle : 1'b1);
  always_comb begin
    for (int b = 0; b < 4; b++) memRdData[8*b +: 8] = memByte(int'(memRdAddr) * 4 + b);
  end

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  // lookup request; expMiss gives the expected outcome (busy one cycle later)
  task automatic lookup(int addr, int len, bit expMiss, string req);
    int cyc = 0;
    int k = 0;
    @(negedge clk);
    reqValid = 1'b1; reqAddr = ADDR_W'(addr); reqLen = LEN_W'(len);
    @(negedge clk);
    reqValid = 1'b0;
    check(busy == expMiss, req, busy, expMiss);
    while (busy) begin
      if (memRdAck) begin
        check(memRdAddr == ADDR_W'(addr + k), "R3 addr", memRdAddr, addr + k);
        k++;
      end
      cyc++;
      @(negedge clk);
    end
    if (expMiss && !slowAck) check(cyc == len, "R3 busy length", cyc, len);
    if (expMiss && slowAck) check(cyc > len, "R9 stalled length", cyc, len + 1);
  endtask

  task automatic sweep(int addr, int len, string req);
    int bad = 0;
    int firstAct = 0;
    int firstExp = 0;
    for (int o = 0; o < len * 4; o++) begin
      fetchOffset = OFF_W'(o);
      #1;
      if (fetchByte !== memByte(addr * 4 + o)) begin
        if (bad == 0) begin firstAct = fetchByte; firstExp = memByte(addr * 4 + o); end
        bad++;
      end
    end
    check(bad == 0, req, firstAct, firstExp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    doReset();
    check(busy == 1'b0, "R1 busy", busy, 0);
    check(memRdReq == 1'b0, "R1 memRdReq", memRdReq, 0);

    // R5: F=100/5, A=200/3, B=300/8
    lookup(100, 5, 1, "R1 R5 first call miss");
    sweep(100, 5, "R4 F bytes");
    lookup(200, 3, 1, "R5 call A miss");
    sweep(200, 3, "R4 A bytes");
    lookup(100, 5, 0, "R5 R2 return F hit");
    sweep(100, 5, "R2 F bytes after hit");
    lookup(300, 8, 1, "R5 call B miss");
    sweep(300, 8, "R4 B bytes full slot");
    lookup(100, 5, 0, "R5 return F hit");
    sweep(100, 5, "R2 F intact");

    // R6
    doReset();
    lookup(100, 5, 1, "R6 call F");
    lookup(200, 3, 1, "R6 call A");
    lookup(300, 2, 1, "R6 call B");
    lookup(200, 3, 0, "R6 return A hit");
    sweep(200, 3, "R6 A bytes");
    lookup(100, 5, 1, "R6 return F miss");
    sweep(100, 5, "R6 F bytes");
    lookup(200, 3, 0, "R6 A kept");

    // R7: long method spans both slots
    doReset();
    lookup(400, 12, 1, "R7 long miss");
    sweep(400, 12, "R7 long bytes");
    lookup(400, 12, 0, "R7 long hit");
    lookup(500, 2, 1, "R7 short miss");
    sweep(500, 2, "R7 short bytes");
    lookup(400, 2 * BW, 1, "R7 long evicted");
    sweep(400, 2 * BW, "R7 max length bytes");
    lookup(500, 2, 1, "R7 short evicted");

    // R8: request during fill is ignored
    doReset();
    @(negedge clk);
    reqValid = 1'b1; reqAddr = 16'd700; reqLen = LEN_W'(4);
    @(negedge clk);
    reqAddr = 16'd800; reqLen = LEN_W'(2);
    check(busy == 1'b1, "R8 fill started", busy, 1);
    @(negedge clk);
    reqValid = 1'b0;
    while (busy) @(negedge clk);
    sweep(700, 4, "R8 fill unchanged");
    lookup(800, 2, 1, "R8 ignored not resident");
    lookup(700, 4, 0, "R8 original resident");

    // R9: stalled acknowledges
    slowAck = 1'b1;
    lookup(900, 6, 1, "R9 slow miss");
    sweep(900, 6, "R9 slow bytes");
    slowAck = 1'b0;
    lookup(900, 6, 0, "R9 hit after slow fill");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule